// File: doc/BRIEF.md
# Prescaled 10-bit PWM Channel Bank

This block drives a small set of pulse-width modulated outputs from one shared reference clock. Each channel slows the reference by a programmable prescaler to make a time quantum. The channel then runs a period that is always 1024 quanta long, and its output is high for a programmable number of those quanta at the start of each period. Software configures the block through a simple byte-wide write port with an address, a data byte and a write strobe. Software has already turned any nanosecond request into codes, so the block only sees the codes.

Each channel owns two adjacent byte registers. One holds the low part of the duty code. The other holds the top duty bits and the frequency code. A single shared control register holds one enable bit per channel. Codes written while a channel runs are staged and take effect at the next period boundary. A channel cannot produce a zero duty while it is enabled. The only way to get a constant low output is to clear its enable bit.

Top module: `pwm_bank`

## Requirements
- R1: After reset, all enable bits, duty codes and frequency codes are zero and every output is low. A channel enabled with these reset codes is high for exactly 32 reference cycles.
- R2: A quantum lasts (32 − F) reference cycles, where F is the channel's 4-bit frequency code. A period lasts 1024 quanta, whatever the duty code is.
- R3: The output is high for (D + 1) quanta at the start of each period and low for the rest, where D is the 10-bit duty code. With D = 1023 the output stays high continuously.
- R4: Channel n's low register sits at address PAIR_BASE + 2n and holds D[7:0]. Its high register sits at PAIR_BASE + 2n + 1 and holds D[9:8] in bits [1:0] and F in bits [7:4]. Writes to bits [3:2] of the high register have no effect.
- R5: The control register sits at CTRL_ADDR, and its bit n enables channel n. After a write that clears bit n, output n is low from the second rising edge after the strobe edge, and it stays low. Other channels are not affected.
- R6: A duty or frequency code written while a channel is enabled does not change the period that is running. It first applies to the period that starts after the current one ends.
- R7: When bit n of the control register goes from 0 to 1, channel n restarts its prescaler and quantum count. Output n is high from the second rising edge after the strobe edge, and it then runs a complete high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; all state updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr | input | ADDR_W | Register address for the write |
| wr_data | input | 8 | Byte to write |
| pwm_out | output | NUM_CH | Registered PWM outputs, one bit per channel |

## Verification
The bench builds the block with three channels and moves the control register to address 8. This leaves two unused addresses between the last channel pair and the control register, so the decode cannot depend on the default layout. The duty width stays at its full 10 bits and the prescaler base stays at 32. Real frequency codes 0, 8, 12 and 15 therefore give exact period lengths of 17408 to 32768 cycles, all inside the run budget. The run reaches a duty code that sets bit 8, continuous high at D = 1023, a code change in the middle of a period, and an enable toggled during the low phase.

// File: rtl/pwmb_pkg.sv
// Package pwmb_pkg
// Holds the types shared by the channel bank.
// Assumes a byte-wide write port. Each channel owns one low byte and one high byte.
package pwmb_pkg;

    // Which register of a channel's pair one write selects
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_LO   = 2'd1,
        TGT_HI   = 2'd2
    } wr_tgt_e;

    // Bit position of the frequency field inside the high byte
    localparam int unsigned FREQ_LSB = 4;

endpackage

// File: rtl/pwmb_regs.sv
// Module pwmb_regs
// Decodes writes into the per-channel staged duty and frequency codes and into
// the shared enable register.
// Assumes 9 <= DUTY_W <= 10 (the top duty bits fit in high-byte bits [1:0]).
// Assumes FREQ_W = 4 (F sits in high-byte bits [7:4]).
// High-byte bits [3:2] are never stored.
module pwmb_regs #(
    parameter int unsigned NUM_CH    = 4,
    parameter int unsigned DUTY_W    = 10,
    parameter int unsigned FREQ_W    = 4,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned PAIR_BASE = 0,
    parameter int unsigned CTRL_ADDR = 15
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [7:0]                      wr_data,
    output logic [NUM_CH-1:0][DUTY_W-1:0]   sh_duty,
    output logic [NUM_CH-1:0][FREQ_W-1:0]   sh_freq,
    output logic [NUM_CH-1:0]               ch_en
);
    import pwmb_pkg::*;

    localparam int unsigned HI_W = DUTY_W - 8;

    // Shared enable register, one bit per channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_en <= '0;
        end else if (wr_en && (wr_addr == ADDR_W'(CTRL_ADDR))) begin
            ch_en <= wr_data[NUM_CH-1:0];
        end
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam int unsigned LO_ADDR = PAIR_BASE + 2 * n;
        localparam int unsigned HI_ADDR = LO_ADDR + 1;

        wr_tgt_e              tgt;
        logic [DUTY_W-1:0]    duty_r;
        logic [FREQ_W-1:0]    freq_r;

        // Select which register of this channel the current write hits
        always_comb begin
            tgt = TGT_NONE;
            if (wr_en && (wr_addr == ADDR_W'(LO_ADDR))) begin
                tgt = TGT_LO;
            end else if (wr_en && (wr_addr == ADDR_W'(HI_ADDR))) begin
                tgt = TGT_HI;
            end
        end

        // Staged duty and frequency codes of this channel
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                duty_r <= '0;
                freq_r <= '0;
            end else begin
                case (tgt)
                    TGT_LO: duty_r[7:0] <= wr_data;
                    TGT_HI: begin
                        duty_r[DUTY_W-1:8] <= wr_data[HI_W-1:0];
                        freq_r             <= wr_data[FREQ_LSB +: FREQ_W];
                    end
                    default: ;
                endcase
            end
        end

        assign sh_duty[n] = duty_r;
        assign sh_freq[n] = freq_r;
    end

endmodule

// File: rtl/pwmb_channel.sv
// Module pwmb_channel
// One PWM channel: a prescaler that counts (DIV_BASE - F) reference cycles per
// quantum, a quantum counter that wraps after 2**DUTY_W quanta, and the duty
// compare.
// While the channel is disabled, both counters are held at zero and the active
// codes follow the staged codes.
// While the channel is enabled, the active codes reload only when a period wraps.
// Assumes DIV_BASE > 2**FREQ_W - 1, so the divisor is never zero.
module pwmb_channel #(
    parameter int unsigned DUTY_W   = 10,
    parameter int unsigned FREQ_W   = 4,
    parameter int unsigned DIV_BASE = 32,
    localparam int unsigned PRE_W   = $clog2(DIV_BASE),
    localparam int unsigned DIV_W   = PRE_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [DUTY_W-1:0]   sh_duty,
    input  logic [FREQ_W-1:0]   sh_freq,
    output logic                level,
    output logic [PRE_W-1:0]    presc,
    output logic [DUTY_W-1:0]   quanta,
    output logic [DUTY_W-1:0]   duty_act,
    output logic [FREQ_W-1:0]   freq_act
);
    logic [DIV_W-1:0] div_last;
    logic             q_end;
    logic             p_end;

    // Last prescaler count of a quantum for the active frequency code
    always_comb begin
        div_last = DIV_W'(DIV_BASE - 1) - DIV_W'(freq_act);
        q_end    = ({1'b0, presc} == div_last);
        p_end    = q_end && (&quanta);
    end

    // Prescaler, quantum counter and active code registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc    <= '0;
            quanta   <= '0;
            duty_act <= '0;
            freq_act <= '0;
        end else if (!en) begin
            presc    <= '0;
            quanta   <= '0;
            duty_act <= sh_duty;
            freq_act <= sh_freq;
        end else if (q_end) begin
            presc  <= '0;
            quanta <= quanta + 1'b1;
            if (p_end) begin
                duty_act <= sh_duty;
                freq_act <= sh_freq;
            end
        end else begin
            presc <= presc + 1'b1;
        end
    end

    // Output level before the output register: high during quanta 0..D
    assign level = en && (quanta <= duty_act);

endmodule

// File: rtl/pwmb_drive.sv
// Module pwmb_drive
// Registers each channel's level onto the output pins, so the outputs carry no
// decode glitches.
// Adds exactly one cycle of latency.
module pwmb_drive #(
    parameter int unsigned NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] level,
    output logic [NUM_CH-1:0] pwm_out
);
    // Output flops, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_out <= '0;
        end else begin
            pwm_out <= level;
        end
    end
endmodule

// File: rtl/pwm_bank.sv
// Module pwm_bank
// Top of the prescaled PWM channel bank: the register decode, NUM_CH channels
// and the output drive.
// Assumes one reference clock for every channel and a synchronous active-low reset.
module pwm_bank #(
    parameter int unsigned NUM_CH    = 4,
    parameter int unsigned DUTY_W    = 10,
    parameter int unsigned FREQ_W    = 4,
    parameter int unsigned DIV_BASE  = 32,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned PAIR_BASE = 0,
    parameter int unsigned CTRL_ADDR = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int unsigned PRE_W = $clog2(DIV_BASE);

    logic [NUM_CH-1:0][DUTY_W-1:0] sh_duty;
    logic [NUM_CH-1:0][FREQ_W-1:0] sh_freq;
    logic [NUM_CH-1:0]             ch_en;
    logic [NUM_CH-1:0]             ch_level;
    logic [NUM_CH-1:0][PRE_W-1:0]  ch_presc;
    logic [NUM_CH-1:0][DUTY_W-1:0] ch_q;
    logic [NUM_CH-1:0][DUTY_W-1:0] ch_dact;
    logic [NUM_CH-1:0][FREQ_W-1:0] ch_fact;

    pwmb_regs #(
        .NUM_CH(NUM_CH), .DUTY_W(DUTY_W), .FREQ_W(FREQ_W),
        .ADDR_W(ADDR_W), .PAIR_BASE(PAIR_BASE), .CTRL_ADDR(CTRL_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sh_duty(sh_duty), .sh_freq(sh_freq), .ch_en(ch_en)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
        pwmb_channel #(
            .DUTY_W(DUTY_W), .FREQ_W(FREQ_W), .DIV_BASE(DIV_BASE)
        ) u_chan (
            .clk(clk), .rst_n(rst_n), .en(ch_en[n]),
            .sh_duty(sh_duty[n]), .sh_freq(sh_freq[n]),
            .level(ch_level[n]), .presc(ch_presc[n]), .quanta(ch_q[n]),
            .duty_act(ch_dact[n]), .freq_act(ch_fact[n])
        );
    end

    pwmb_drive #(.NUM_CH(NUM_CH)) u_drive (
        .clk(clk), .rst_n(rst_n), .level(ch_level), .pwm_out(pwm_out)
    );

endmodule

// File: rtl/pwm_bank_chk.sv
// Module pwm_bank_chk
// Property checker for pwm_bank, attached to it by the bind statement at the
// end of this file.
// Observes the ports and the per-channel counters and active codes.
module pwm_bank_chk #(
    parameter int unsigned NUM_CH    = 4,
    parameter int unsigned DUTY_W    = 10,
    parameter int unsigned FREQ_W    = 4,
    parameter int unsigned DIV_BASE  = 32,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned CTRL_ADDR = 15,
    localparam int unsigned PRE_W    = $clog2(DIV_BASE),
    localparam int unsigned DIV_W    = PRE_W + 1
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en,
    input logic [ADDR_W-1:0]               wr_addr,
    input logic [7:0]                      wr_data,
    input logic [NUM_CH-1:0]               pwm_out,
    input logic [NUM_CH-1:0]               ch_en,
    input logic [NUM_CH-1:0][PRE_W-1:0]    ch_presc,
    input logic [NUM_CH-1:0][DUTY_W-1:0]   ch_q,
    input logic [NUM_CH-1:0][DUTY_W-1:0]   ch_dact,
    input logic [NUM_CH-1:0][FREQ_W-1:0]   ch_fact
);
    // R5
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == ADDR_W'(CTRL_ADDR)))
        |=> (ch_en == $past(wr_data[NUM_CH-1:0])));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_prop
        // R5
        off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pwm_out[n] |-> $past(ch_en[n]));

        // R7
        start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_en[n]) |=> pwm_out[n]);

        // R2
        presc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ({1'b0, ch_presc[n]} < (DIV_W'(DIV_BASE) - DIV_W'(ch_fact[n]))));

        // R6
        duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[n] && $past(ch_en[n]) && (ch_q[n] != '0))
            |-> ($stable(ch_dact[n]) && $stable(ch_fact[n])));
    end
endmodule

bind pwm_bank pwm_bank_chk #(
    .NUM_CH(NUM_CH), .DUTY_W(DUTY_W), .FREQ_W(FREQ_W),
    .DIV_BASE(DIV_BASE), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .ch_en(ch_en),
    .ch_presc(ch_presc), .ch_q(ch_q), .ch_dact(ch_dact), .ch_fact(ch_fact)
);

// File: tb/tb_pwm_bank.sv
// Directed bench for pwm_bank: one task per scenario, each checking its own
// results at the falling clock edge.
module tb_pwm_bank;
    localparam int CLK_NS  = 10;
    localparam int NCH     = 3;
    localparam int CTRL    = 8;
    localparam int WDOG    = 190000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [3:0]     wr_addr = '0;
    logic [7:0]     wr_data = '0;
    logic [NCH-1:0] pwm_out;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_NS/2) clk = ~clk;

    pwm_bank #(
        .NUM_CH(NCH), .DUTY_W(10), .FREQ_W(4), .DIV_BASE(32),
        .ADDR_W(4), .PAIR_BASE(0), .CTRL_ADDR(CTRL)
    ) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One register write: strobe held for one rising edge
    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 4'(addr);
        wr_data = 8'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Samples at falling edges until a 0->1 transition of channel ch
    task automatic wait_rise(input int ch, input int limit, output int n);
        logic prev;
        prev = pwm_out[ch];
        n = 0;
        while (n < limit) begin
            @(negedge clk);
            n++;
            if (pwm_out[ch] && !prev) break;
            prev = pwm_out[ch];
        end
    endtask

    // Length of the current run of equal samples, counting the present one
    task automatic run_len(input int ch, input int limit, output int n);
        logic lvl;
        lvl = pwm_out[ch];
        n = 1;
        while (n < limit) begin
            @(negedge clk);
            if (pwm_out[ch] !== lvl) break;
            n++;
        end
    endtask

    // R1: reset state, and a channel enabled with the reset codes
    task automatic t_reset();
        int w, h;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1", "outputs during reset", pwm_out, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "outputs after reset", pwm_out, 0);
        wr(CTRL, 8'h01);
        wait_rise(0, 10, w);
        chk("R1", "rise after enable with reset codes", w, 1);
        run_len(0, 100, h);
        chk("R1", "high time with D=0 F=0", h, 32);
        wr(CTRL, 8'h00);
        repeat (2) @(negedge clk);
        chk("R1", "outputs after disable", pwm_out, 0);
    endtask

    // R2 R3 R4: three channels with distinct codes run side by side
    task automatic t_main();
        wr(0, 8'h63); wr(1, 8'hF0);   // ch0 D=99  F=15
        wr(2, 8'hFF); wr(3, 8'h03);   // ch1 D=1023 F=0
        wr(4, 8'h2C); wr(5, 8'h8D);   // ch2 D=300 F=8, bits [3:2] set (ignored)
        wr(CTRL, 8'h07);
        fork
            begin
                int w, h, l;
                wait_rise(0, 10, w);
                chk("R7", "ch0 first rise", w, 1);
                run_len(0, 40000, h);
                chk("R3", "ch0 high time D=99 F=15", h, 1700);
                run_len(0, 40000, l);
                chk("R2", "ch0 period F=15", h + l, 17408);
            end
            begin
                int w, h;
                wait_rise(1, 10, w);
                chk("R7", "ch1 first rise", w, 1);
                run_len(1, 33000, h);
                chk("R3", "ch1 continuous high D=1023", h, 33000);
            end
            begin
                int w, h, l;
                wait_rise(2, 10, w);
                chk("R7", "ch2 first rise", w, 1);
                run_len(2, 40000, h);
                chk("R4", "ch2 high time D=300 F=8, bits 3:2 ignored", h, 7224);
                run_len(2, 40000, l);
                chk("R2", "ch2 period F=8", h + l, 24576);
            end
        join
    endtask

    // R6: codes written during a period apply only from the next one
    task automatic t_shadow();
        int w;
        wait_rise(0, 40000, w);
        fork
            begin
                int h1, l1, h2, l2;
                run_len(0, 40000, h1);
                chk("R6", "high time of running period kept", h1, 1700);
                run_len(0, 40000, l1);
                chk("R6", "running period length kept", h1 + l1, 17408);
                run_len(0, 40000, h2);
                chk("R6", "next period high time D=499 F=12", h2, 10000);
                run_len(0, 40000, l2);
                chk("R6", "next period length F=12", h2 + l2, 20480);
            end
            begin
                repeat (50) @(negedge clk);
                wr(0, 8'hF3);
                wr(1, 8'hC1);
            end
        join
    endtask

    // R5: clearing one enable bit forces that output low, others untouched
    task automatic t_disable();
        int w, l;
        wait_rise(0, 40000, w);
        repeat (20) @(negedge clk);
        wr(CTRL, 8'h06);
        @(negedge clk);
        chk("R5", "ch0 low after disable", pwm_out[0], 0);
        chk("R5", "ch1 unaffected by ch0 disable", pwm_out[1], 1);
        run_len(0, 2000, l);
        chk("R5", "ch0 stays low while disabled", l, 2000);
    endtask

    // R7: re-enable restarts the period with the high phase, also mid-period
    task automatic t_restart();
        int w, h;
        wr(CTRL, 8'h07);
        wait_rise(0, 10, w);
        chk("R7", "rise after re-enable", w, 1);
        run_len(0, 40000, h);
        chk("R7", "full high phase after re-enable", h, 10000);
        repeat (100) @(negedge clk);
        wr(CTRL, 8'h06);
        wr(CTRL, 8'h07);
        wait_rise(0, 10, w);
        chk("R7", "rise after toggle in low phase", w, 1);
        run_len(0, 40000, h);
        chk("R7", "full high phase after toggle", h, 10000);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (WDOG) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d cycles", WDOG, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_main();
        t_shadow();
        t_disable();
        t_restart();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule